// File: doc/BRIEF.md
# Selectable Event Counter with Occupancy Histogram

This block watches a bus bridge and counts one chosen kind of activity. Every cycle the bridge presents a vector of one-cycle event strobes (channel handshakes, ready wait states, FIFO-full flags, latency-deadline misses, device clock on/off, zero-length burst handshakes). It also presents its current outstanding read and write counts. Software writes a 6-bit selector code. For most codes, one 32-bit saturating counter increments on the chosen strobe. Software can also read and overwrite that counter.

Two selector codes put the block in histogram mode. In that mode, each cycle the block takes the outstanding read or outstanding write count, clamps it to 15, and increments the matching bin of a 16-bin histogram. The main counter holds its value while the histogram runs. A 4-bit bin-select register chooses which bin appears on the 32-bit read port. Software also writes bins through that port.

The selector is held in a four-state machine. The states are MON_OFF, MON_CYCLE, MON_EVENT and MON_HIST. A selector write moves the machine to the state that the written code decodes to, and the machine holds that state until the next selector write. MON_OFF is entered for code 0 and for every unused code. MON_CYCLE is entered for code 1. MON_EVENT is entered for a single-strobe code. MON_HIST is entered for code 16 or 17.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset, the counter reads 0, every histogram bin reads 0, the selector is in MON_OFF and the bin select is 0.
- R2: With selector code 0, or any code not listed in R3 to R6 or R10 (for example 20 or 33), neither the counter nor any bin changes, whatever the strobes do.
- R3: Code 1 increments the counter in every cycle.
- R4: Codes 2 to 15 count strobe bit (code - 2). The bit assignment is:
  - bit 0: read deadline miss
  - bit 1: write deadline miss
  - bits 2 to 6: full flag of the read-address, write-address, read-data, write-data and write-response FIFO
  - bit 7: read ready wait
  - bit 8: response ready wait
  - bits 9 to 13: handshake on R, W, B, AR and AW
- R5: Code 18 counts strobe bit 14 (device clock on), and code 19 counts strobe bit 15 (device clock off).
- R6: Code 32 counts strobe bit 16 (read-address handshake with burst length 0), and code 48 counts strobe bit 17 (write-address handshake with burst length 0).
- R7: A selector write changes behaviour from the next cycle on. In the write cycle itself the old selection still counts. A counted event shows on `cnt_rd_data` one clock after its cycle.
- R8: A counter write loads `cnt_wr_data`, and the written value shows on the next cycle. A write takes priority over an increment in the same cycle.
- R9: The counter and every bin stop at 0xFFFFFFFF and do not wrap.
- R10: Code 16 (outstanding reads) and code 17 (outstanding writes) add one per cycle to the bin whose index is min(outstanding, 15). The counter holds its value in this mode.
- R11: `bin_rd_data` shows the bin chosen by the bin-select register. A bin write goes to that bin and takes priority over a histogram increment of the same bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_code | input | 6 | Selector code to write |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 32 | Counter write value |
| cnt_rd_data | output | 32 | Current counter value |
| bin_sel_wr_en | input | 1 | Bin-select write strobe |
| bin_sel_wr_data | input | 4 | Bin index to select |
| bin_wr_en | input | 1 | Write strobe for the selected bin |
| bin_wr_data | input | 32 | Value for the selected bin |
| bin_rd_data | output | 32 | Value of the selected bin |
| ev_strobe | input | 18 | Per-cycle event strobes, bit map in R4 to R6 |
| rd_outstanding | input | 7 | Outstanding read count |
| wr_outstanding | input | 7 | Outstanding write count |

## Verification
Every register in the result path is one flop deep, so counter and bin values are due one clock after the cycle of the stimulus that causes them. A selector write lands at the same edge as any event in that cycle, so the old code still applies to that event. The bench drives inputs just after each falling edge and samples the outputs at the next falling edge. Its expected counts therefore include the cycle in which a selector write is made. A bin readback uses one cycle to write the bin select, after which the read data is combinational from that register.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int CNT_W    = 32;
    localparam int SEL_W    = 6;
    localparam int NUM_EV   = 18;
    localparam int EV_IDX_W = $clog2(NUM_EV);
    localparam int NUM_BINS = 16;
    localparam int BIN_W    = $clog2(NUM_BINS);
    localparam int OCC_W    = 7;

    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_CYCLE = 2'd1,
        MON_EVENT = 2'd2,
        MON_HIST  = 2'd3
    } mon_state_e;

    typedef struct packed {
        mon_state_e            state;
        logic [EV_IDX_W-1:0]   ev_idx;
        logic                  hist_wr_side;
    } sel_decode_t;

    // Sparse selector code -> monitor state, strobe index, histogram source.
    function automatic sel_decode_t decode_sel(input logic [SEL_W-1:0] code);
        sel_decode_t d;
        logic [SEL_W-1:0] off;
        d.state        = MON_OFF;
        d.ev_idx       = '0;
        d.hist_wr_side = 1'b0;
        off            = code - SEL_W'(2);
        case (code) inside
            SEL_W'(1): d.state = MON_CYCLE;
            [SEL_W'(2):SEL_W'(15)]: begin
                d.state  = MON_EVENT;
                d.ev_idx = off[EV_IDX_W-1:0];
            end
            SEL_W'(16): d.state = MON_HIST;
            SEL_W'(17): begin
                d.state        = MON_HIST;
                d.hist_wr_side = 1'b1;
            end
            SEL_W'(18): begin
                d.state  = MON_EVENT;
                d.ev_idx = EV_IDX_W'(14);
            end
            SEL_W'(19): begin
                d.state  = MON_EVENT;
                d.ev_idx = EV_IDX_W'(15);
            end
            SEL_W'(32): begin
                d.state  = MON_EVENT;
                d.ev_idx = EV_IDX_W'(16);
            end
            SEL_W'(48): begin
                d.state  = MON_EVENT;
                d.ev_idx = EV_IDX_W'(17);
            end
            default: d.state = MON_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/perf_sel_fsm.sv
module perf_sel_fsm
    import perf_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr_en,
    input  logic [SEL_W-1:0]    sel_wr_code,
    output logic                cyc_en,
    output logic                ev_en,
    output logic                hist_en,
    output logic [EV_IDX_W-1:0] ev_idx,
    output logic                hist_wr_side
);

    mon_state_e          state_q, state_d;
    logic [EV_IDX_W-1:0] idx_q, idx_d;
    logic                side_q, side_d;
    sel_decode_t         dec;

    assign dec = decode_sel(sel_wr_code);

    // Next state: a selector write jumps to the decoded state, else hold.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        side_d  = side_q;
        if (sel_wr_en) begin
            state_d = dec.state;
            idx_d   = dec.ev_idx;
            side_d  = dec.hist_wr_side;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
            idx_q   <= '0;
            side_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            side_q  <= side_d;
        end
    end

    // Outputs per state.
    always_comb begin
        cyc_en  = 1'b0;
        ev_en   = 1'b0;
        hist_en = 1'b0;
        unique case (state_q)
            MON_OFF:   ;
            MON_CYCLE: cyc_en  = 1'b1;
            MON_EVENT: ev_en   = 1'b1;
            MON_HIST:  hist_en = 1'b1;
        endcase
    end

    assign ev_idx       = idx_q;
    assign hist_wr_side = side_q;

    // R1 / R2: selector resets to the idle state, so nothing is counted.
    a_r1_off_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_q == MON_OFF));

    // R7: the state only moves when software writes the selector.
    a_r7_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr_en |=> $stable(state_q));

    // At most one counting mode is active at any time.
    a_r10_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cyc_en, ev_en, hist_en}));

endmodule

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)
            cnt_d = wr_data;
        else if (inc && cnt_q != MAXV)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q = cnt_q;

    // R9: a full count never rolls over to zero.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !wr_en) |=> (cnt_q == MAXV));

    // R8: a write lands exactly.
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

    // R3: without a write the count advances by at most one.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/perf_event_pick.sv
module perf_event_pick #(
    parameter int NUM_EV   = 18,
    parameter int EV_IDX_W = 5
) (
    input  logic [NUM_EV-1:0]   ev_strobe,
    input  logic [EV_IDX_W-1:0] ev_idx,
    input  logic                cyc_en,
    input  logic                ev_en,
    output logic                hit
);

    localparam int PAD_N = 1 << EV_IDX_W;

    logic [PAD_N-1:0] padded;

    assign padded = PAD_N'(ev_strobe);
    assign hit    = cyc_en | (ev_en & padded[ev_idx]);

endmodule

// File: rtl/perf_histogram.sv
module perf_histogram #(
    parameter int NUM_BINS = 16,
    parameter int CNT_W    = 32,
    parameter int OCC_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hist_en,
    input  logic                        hist_wr_side,
    input  logic [OCC_W-1:0]            rd_occ,
    input  logic [OCC_W-1:0]            wr_occ,
    input  logic                        bin_sel_wr_en,
    input  logic [$clog2(NUM_BINS)-1:0] bin_sel_wr_data,
    input  logic                        bin_wr_en,
    input  logic [CNT_W-1:0]            bin_wr_data,
    output logic [CNT_W-1:0]            bin_rd_data
);

    localparam int BIN_W = $clog2(NUM_BINS);
    localparam logic [OCC_W-1:0] TOP_OCC = OCC_W'(NUM_BINS - 1);

    logic [BIN_W-1:0]    bin_sel_q;
    logic [OCC_W-1:0]    occ;
    logic [BIN_W-1:0]    bin_hit;
    logic [NUM_BINS-1:0] inc_vec;
    logic [NUM_BINS-1:0] wr_vec;
    logic [CNT_W-1:0]    bin_val [NUM_BINS];

    always_ff @(posedge clk) begin
        if (!rst_n)             bin_sel_q <= '0;
        else if (bin_sel_wr_en) bin_sel_q <= bin_sel_wr_data;
    end

    assign occ = hist_wr_side ? wr_occ : rd_occ;

    // Clamp the outstanding count onto the last bin.
    always_comb begin
        if (occ >= TOP_OCC) bin_hit = BIN_W'(NUM_BINS - 1);
        else                bin_hit = occ[BIN_W-1:0];
    end

    for (genvar i = 0; i < NUM_BINS; i++) begin : g_bin
        assign inc_vec[i] = hist_en   && (bin_hit   == BIN_W'(i));
        assign wr_vec[i]  = bin_wr_en && (bin_sel_q == BIN_W'(i));
        perf_sat_counter #(.W(CNT_W)) u_bin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_vec[i]),
            .wr_data (bin_wr_data),
            .inc     (inc_vec[i]),
            .q       (bin_val[i])
        );
    end

    assign bin_rd_data = bin_val[bin_sel_q];

    // R10: at most one bin is touched by the histogram per cycle.
    a_r10_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc_vec) <= 1);

    // R11: a bin write is visible on the read port next cycle.
    a_r11_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_wr_en && !bin_sel_wr_en) |=> (bin_rd_data == $past(bin_wr_data)));

endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
    import perf_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr_en,
    input  logic [SEL_W-1:0]    sel_wr_code,
    input  logic                cnt_wr_en,
    input  logic [CNT_W-1:0]    cnt_wr_data,
    output logic [CNT_W-1:0]    cnt_rd_data,
    input  logic                bin_sel_wr_en,
    input  logic [BIN_W-1:0]    bin_sel_wr_data,
    input  logic                bin_wr_en,
    input  logic [CNT_W-1:0]    bin_wr_data,
    output logic [CNT_W-1:0]    bin_rd_data,
    input  logic [NUM_EV-1:0]   ev_strobe,
    input  logic [OCC_W-1:0]    rd_outstanding,
    input  logic [OCC_W-1:0]    wr_outstanding
);

    logic                cyc_en, ev_en, hist_en, hist_wr_side, hit;
    logic [EV_IDX_W-1:0] ev_idx;

    perf_sel_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_wr_en    (sel_wr_en),
        .sel_wr_code  (sel_wr_code),
        .cyc_en       (cyc_en),
        .ev_en        (ev_en),
        .hist_en      (hist_en),
        .ev_idx       (ev_idx),
        .hist_wr_side (hist_wr_side)
    );

    perf_event_pick #(.NUM_EV(NUM_EV), .EV_IDX_W(EV_IDX_W)) u_pick (
        .ev_strobe (ev_strobe),
        .ev_idx    (ev_idx),
        .cyc_en    (cyc_en),
        .ev_en     (ev_en),
        .hit       (hit)
    );

    perf_sat_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .inc     (hit),
        .q       (cnt_rd_data)
    );

    perf_histogram #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_hist (
        .clk             (clk),
        .rst_n           (rst_n),
        .hist_en         (hist_en),
        .hist_wr_side    (hist_wr_side),
        .rd_occ          (rd_outstanding),
        .wr_occ          (wr_outstanding),
        .bin_sel_wr_en   (bin_sel_wr_en),
        .bin_sel_wr_data (bin_sel_wr_data),
        .bin_wr_en       (bin_wr_en),
        .bin_wr_data     (bin_wr_data),
        .bin_rd_data     (bin_rd_data)
    );

    // R10: the event counter is frozen while the histogram runs.
    a_r10_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_en && !cnt_wr_en) |=> $stable(cnt_rd_data));

    // R2: in the idle state the counter never moves.
    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !ev_en && !cnt_wr_en) |=> $stable(cnt_rd_data));

endmodule

// File: tb/test_perf_event_monitor.sv
module test_perf_event_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_wr_en;
    logic [5:0]  sel_wr_code;
    logic        cnt_wr_en;
    logic [31:0] cnt_wr_data;
    logic [31:0] cnt_rd_data;
    logic        bin_sel_wr_en;
    logic [3:0]  bin_sel_wr_data;
    logic        bin_wr_en;
    logic [31:0] bin_wr_data;
    logic [31:0] bin_rd_data;
    logic [17:0] ev_strobe;
    logic [6:0]  rd_outstanding;
    logic [6:0]  wr_outstanding;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    perf_event_monitor i_perf_event_monitor (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_wr_en       (sel_wr_en),
        .sel_wr_code     (sel_wr_code),
        .cnt_wr_en       (cnt_wr_en),
        .cnt_wr_data     (cnt_wr_data),
        .cnt_rd_data     (cnt_rd_data),
        .bin_sel_wr_en   (bin_sel_wr_en),
        .bin_sel_wr_data (bin_sel_wr_data),
        .bin_wr_en       (bin_wr_en),
        .bin_wr_data     (bin_wr_data),
        .bin_rd_data     (bin_rd_data),
        .ev_strobe       (ev_strobe),
        .rd_outstanding  (rd_outstanding),
        .wr_outstanding  (wr_outstanding)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One clock; returns just after the falling edge.
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_sel(input logic [5:0] code);
        sel_wr_en = 1'b1; sel_wr_code = code;
        step(1);
        sel_wr_en = 1'b0;
    endtask

    task automatic write_cnt(input logic [31:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        step(1);
        cnt_wr_en = 1'b0;
    endtask

    task automatic pick_bin(input logic [3:0] b);
        bin_sel_wr_en = 1'b1; bin_sel_wr_data = b;
        step(1);
        bin_sel_wr_en = 1'b0;
    endtask

    task automatic write_bin(input logic [31:0] v);
        bin_wr_en = 1'b1; bin_wr_data = v;
        step(1);
        bin_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 counter", cnt_rd_data, 32'd0);
        check("R1 bin0", bin_rd_data, 32'd0);
        pick_bin(4'd15);
        check("R1 bin15", bin_rd_data, 32'd0);
        pick_bin(4'd0);
    endtask

    task automatic t_off;
        ev_strobe = '1;
        step(6);
        check("R2 code0 holds", cnt_rd_data, 32'd0);
        set_sel(6'd33);
        step(5);
        check("R2 code33 holds", cnt_rd_data, 32'd0);
        set_sel(6'd20);
        step(5);
        check("R2 code20 holds", cnt_rd_data, 32'd0);
        ev_strobe = '0;
    endtask

    task automatic t_cycles;
        set_sel(6'd1);
        step(7);
        check("R3 every cycle", cnt_rd_data, 32'd7);
        // R7: the cycle of the selector write still counts with code 1.
        set_sel(6'd0);
        check("R7 old code in write cycle", cnt_rd_data, 32'd8);
        step(3);
        check("R7 new code after write", cnt_rd_data, 32'd8);
    endtask

    // Target strobe on in 3 of 8 cycles, every other strobe on always.
    task automatic t_event(input logic [5:0] code, input int bitn, input string req);
        set_sel(6'd0);
        write_cnt(32'd0);
        set_sel(code);
        for (int k = 0; k < 8; k++) begin
            ev_strobe = '1;
            ev_strobe[bitn] = (k % 3 == 0);
            step(1);
        end
        ev_strobe = '0;
        check(req, cnt_rd_data, 32'd3);
    endtask

    task automatic t_write;
        set_sel(6'd1);
        write_cnt(32'h1234_5678);
        check("R8 write beats increment", cnt_rd_data, 32'h1234_5678);
        step(1);
        check("R8 counts on from written value", cnt_rd_data, 32'h1234_5679);
    endtask

    task automatic t_sat;
        set_sel(6'd0);
        write_cnt(32'hFFFF_FFFD);
        set_sel(6'd1);
        step(5);
        check("R9 counter saturates", cnt_rd_data, 32'hFFFF_FFFF);
        set_sel(6'd0);
    endtask

    task automatic t_hist;
        write_cnt(32'h55);
        wr_outstanding = 7'd2;
        set_sel(6'd16);
        rd_outstanding = 7'd0;  step(2);
        rd_outstanding = 7'd3;  step(4);
        rd_outstanding = 7'd40; step(5);
        rd_outstanding = 7'd15; step(1);
        rd_outstanding = 7'd9;
        set_sel(6'd0);
        rd_outstanding = 7'd0;
        check("R10 counter frozen", cnt_rd_data, 32'h55);
        pick_bin(4'd0);  check("R10 bin0", bin_rd_data, 32'd2);
        pick_bin(4'd3);  check("R10 bin3", bin_rd_data, 32'd4);
        pick_bin(4'd15); check("R10 bin15 clamp", bin_rd_data, 32'd6);
        pick_bin(4'd9);  check("R7 hist in write cycle", bin_rd_data, 32'd1);
        pick_bin(4'd2);  check("R10 other side ignored", bin_rd_data, 32'd0);
        rd_outstanding = 7'd1;
        wr_outstanding = 7'd7;
        set_sel(6'd17);
        step(3);
        set_sel(6'd0);
        wr_outstanding = 7'd0;
        pick_bin(4'd7);  check("R10 write side bin7", bin_rd_data, 32'd4);
        pick_bin(4'd1);  check("R10 read side unused", bin_rd_data, 32'd0);
    endtask

    task automatic t_binwr;
        pick_bin(4'd5);
        write_bin(32'hABCD_0001);
        check("R11 bin write readback", bin_rd_data, 32'hABCD_0001);
        rd_outstanding = 7'd5;
        set_sel(6'd16);
        write_bin(32'h10);
        check("R11 bin write beats increment", bin_rd_data, 32'h10);
        step(2);
        set_sel(6'd0);
        check("R11 selected bin counts", bin_rd_data, 32'h13);
        write_bin(32'hFFFF_FFFE);
        set_sel(6'd16);
        step(3);
        set_sel(6'd0);
        check("R9 bin saturates", bin_rd_data, 32'hFFFF_FFFF);
        rd_outstanding = 7'd0;
    endtask

    initial begin
        rst_n = 1'b0;
        sel_wr_en = 0; sel_wr_code = '0; cnt_wr_en = 0; cnt_wr_data = '0;
        bin_sel_wr_en = 0; bin_sel_wr_data = '0; bin_wr_en = 0; bin_wr_data = '0;
        ev_strobe = '0; rd_outstanding = '0; wr_outstanding = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_off;
        t_cycles;
        for (int c = 2; c <= 15; c++)
            t_event(6'(c), c - 2, "R4 single strobe code");
        t_event(6'd18, 14, "R5 clock on");
        t_event(6'd19, 15, "R5 clock off");
        t_event(6'd32, 16, "R6 AR zero length");
        t_event(6'd48, 17, "R6 AW zero length");
        t_write;
        t_sat;
        t_hist;
        t_binwr;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule